// File: doc/BRIEF.md
# Tuning Wheel Status Register

This block is a small status register that a processor reads over its bus to learn whether the front-panel tuning wheel has moved and which way it turned. Two sensing signals from upstream wheel logic, one meaning "the wheel is turning" and one giving the direction, are held in two flag bits. A direction value of 1 means clockwise, so the displayed frequency should rise by the selected step. A value of 0 means counterclockwise, so it should fall. Quadrature decoding and frequency stepping happen elsewhere.

The flags are loaded on each rising edge of a separate capture clock, but only while both active-low gate inputs are low. The two wheel signals and the capture clock are asynchronous, so each passes through a two-stage synchronizer into the bus clock domain. There, a rising edge of the synchronized capture clock loads the synchronized wheel values. The processor sees the flags only while its active-low read strobe is low and the address equals the status address. At every other time the data output is 0 and its enable is low; the bus-side tri-state is modelled as data plus enable. A read at a second address clears both flags synchronously. A read of the status address leaves them unchanged.

Top module: `wheel_status_reg`

## Requirements
- R1: While reset is held, and after its release until the first capture, both flags are 0 and a status read returns 0.
- R2: With the read strobe low and the address at 0x1040, the output enable is 1 in that same cycle. The data is {6'b0, direction, rotating}: bit 0 is rotating and bit 1 is direction, with 1 meaning clockwise.
- R3: With the read strobe high, or with any address other than 0x1040, the output enable is 0 and the data output is 0.
- R4: A rising edge on the capture clock with both gate inputs low loads the wheel values into the flags. Wheel values and capture edge applied together are readable after the third rising bus-clock edge.
- R5: If either gate input is high at the capture edge, the flags keep their previous value.
- R6: A read with the strobe low and the address at 0x1048 on a bus-clock edge clears both flags at that edge. The output enable stays 0 during this read.
- R7: Holding a read of 0x1040 across bus-clock edges does not change the flags.
- R8: If a clear and a capture fall on the same bus-clock edge, the clear wins and both flags are 0.
- R9: While the capture clock stays high, changes on the wheel inputs do not reach the flags; only a new rising edge loads them.
- R10: Data bits 7:2 always read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wheel_turn_i | input | 1 | Asynchronous "wheel turning" indication |
| wheel_cw_i | input | 1 | Asynchronous direction, 1 = clockwise |
| cap_clk_i | input | 1 | Asynchronous capture clock, rising edge loads |
| gate_n_i | input | 2 | Active-low capture gates, both low to load |
| addr_i | input | 16 | Processor address |
| rd_n_i | input | 1 | Active-low read strobe |
| rd_data_o | output | 8 | Read data, 0 when not enabled |
| rd_oe_o | output | 1 | Output enable for the bus driver |

## Verification
The read path is combinational. The bench therefore sets the address and strobe just after a falling clock edge and samples data and enable one time unit later, with no clock edge in between. A capture passes two synchronizer stages and then the flag register, so it is due after the third rising edge following the stimulus. The bench waits exactly three edges and reads at the following falling edge. A clear is due at the single rising edge on which the clear read is held. For the priority case, the clear read is placed on the same edge at which the synchronized capture edge fires.

// File: rtl/wsr_pkg.sv
// Package for the tuning wheel status register: flag layout and widths.
package wsr_pkg;
    localparam int FLAG_W = 2;

    // Stored flags; bit 0 rotating, bit 1 clockwise.
    typedef struct packed {
        logic cw;
        logic rotating;
    } wheel_flags_t;
endpackage

// File: rtl/wsr_sync.sv
// Multi-stage synchronizer for a bundle of asynchronous level signals.
// Assumes each input is a slow level, so per-bit resolution is enough.
module wsr_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] chain [STAGES];

    // First stage samples the asynchronous inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= '0;
        else        chain[0] <= async_i;
    end

    // Each further stage copies its predecessor.
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= chain[s-1];
        end
    end

    assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/wsr_decode.sv
// Address decoder: produces the status-read select and the clear select.
// Assumes both selects require the active-low read strobe to be low.
module wsr_decode #(
    parameter int             ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 16'h1040,
    parameter logic [ADDR_W-1:0] CLR_ADDR  = 16'h1048
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              rd_n_i,
    output logic              sel_stat_o,
    output logic              sel_clr_o
);
    // Compare the address against both decoded locations.
    always_comb begin
        sel_stat_o = !rd_n_i && (addr_i == STAT_ADDR);
        sel_clr_o  = !rd_n_i && (addr_i == CLR_ADDR);
    end
endmodule

// File: rtl/wsr_flags.sv
// Flag storage: loads synchronized wheel values on a rising edge of the
// synchronized capture clock when both gates are low; clear has priority.
// Assumes all inputs are already in the clk domain.
module wsr_flags
    import wsr_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cap_lvl_i,
    input  logic [1:0]   gate_n_i,
    input  wheel_flags_t wheel_i,
    input  logic         clear_i,
    output wheel_flags_t flags_o
);
    logic cap_prev;
    logic cap_fire;

    // Remember the previous capture level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) cap_prev <= 1'b0;
        else        cap_prev <= cap_lvl_i;
    end

    // A load happens on a rising capture edge with both gates open.
    always_comb cap_fire = cap_lvl_i && !cap_prev && (gate_n_i == 2'b00);

    // Update flags: clear first, then capture, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n)        flags_o <= '0;
        else if (clear_i)  flags_o <= '0;
        else if (cap_fire) flags_o <= wheel_i;
    end

    assert_clear_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (flags_o == '0));
    assert_capture_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_fire && !clear_i) |=> (flags_o == $past(wheel_i)));
    assert_gate_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((gate_n_i != 2'b00) && !clear_i) |=> $stable(flags_o));
    assert_level_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_prev && !clear_i) |=> $stable(flags_o));
endmodule

// File: rtl/wheel_status_reg.sv
// Top: processor-readable tuning wheel status register.
// Assumes wheel inputs and capture clock are asynchronous to clk, and
// that the bus tri-state is built outside from rd_data_o and rd_oe_o.
module wheel_status_reg
    import wsr_pkg::*;
#(
    parameter int                ADDR_W      = 16,
    parameter int                DATA_W      = 8,
    parameter int                SYNC_STAGES = 2,
    parameter logic [ADDR_W-1:0] STAT_ADDR   = 16'h1040,
    parameter logic [ADDR_W-1:0] CLR_ADDR    = 16'h1048
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wheel_turn_i,
    input  logic              wheel_cw_i,
    input  logic              cap_clk_i,
    input  logic [1:0]        gate_n_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              rd_n_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              rd_oe_o
);
    localparam int SYNC_W = FLAG_W + 1;
    localparam int PAD_W  = DATA_W - FLAG_W;

    logic [SYNC_W-1:0] sync_q;
    wheel_flags_t      wheel_s;
    wheel_flags_t      flags;
    logic              sel_stat;
    logic              sel_clr;

    wsr_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({cap_clk_i, wheel_cw_i, wheel_turn_i}),
        .sync_o  (sync_q)
    );

    // Repack the synchronized wheel bits as a flag record.
    always_comb begin
        wheel_s.rotating = sync_q[0];
        wheel_s.cw       = sync_q[1];
    end

    wsr_decode #(.ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR), .CLR_ADDR(CLR_ADDR)) u_dec (
        .addr_i     (addr_i),
        .rd_n_i     (rd_n_i),
        .sel_stat_o (sel_stat),
        .sel_clr_o  (sel_clr)
    );

    wsr_flags u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_lvl_i (sync_q[SYNC_W-1]),
        .gate_n_i  (gate_n_i),
        .wheel_i   (wheel_s),
        .clear_i   (sel_clr),
        .flags_o   (flags)
    );

    // Drive the bus only on a status read; otherwise present zero.
    always_comb begin
        rd_oe_o   = sel_stat;
        rd_data_o = sel_stat ? {{PAD_W{1'b0}}, flags} : '0;
    end

    assert_oe_needs_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_oe_o |-> (!rd_n_i && addr_i == STAT_ADDR));
    assert_stat_read_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_stat && !u_flags.cap_fire) |=> $stable(flags));
endmodule

// File: tb/tb_wheel_status_reg.sv
module tb_wheel_status_reg;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wheel_turn_i = 1'b0;
    logic        wheel_cw_i = 1'b0;
    logic        cap_clk_i = 1'b0;
    logic [1:0]  gate_n_i = 2'b00;
    logic [15:0] addr_i = 16'h0000;
    logic        rd_n_i = 1'b1;
    logic [7:0]  rd_data_o;
    logic        rd_oe_o;

    int checks = 0;
    int errors = 0;

    wheel_status_reg dut (
        .clk(clk), .rst_n(rst_n), .wheel_turn_i(wheel_turn_i), .wheel_cw_i(wheel_cw_i),
        .cap_clk_i(cap_clk_i), .gate_n_i(gate_n_i), .addr_i(addr_i), .rd_n_i(rd_n_i),
        .rd_data_o(rd_data_o), .rd_oe_o(rd_oe_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Status read between edges; returns {oe, data}.
    task automatic stat_read(output logic [8:0] res);
        @(negedge clk);
        addr_i = 16'h1040; rd_n_i = 1'b0;
        #1 res = {rd_oe_o, rd_data_o};
        #1 rd_n_i = 1'b1;
    endtask

    // Clear read held across one rising edge.
    task automatic clear_read(input string req);
        @(negedge clk);
        addr_i = 16'h1048; rd_n_i = 1'b0;
        #1 check(req, {rd_oe_o, rd_data_o}, 9'h000);
        @(posedge clk);
        @(negedge clk);
        rd_n_i = 1'b1;
    endtask

    // Apply wheel values with a capture rising edge, wait three edges.
    task automatic capture(input logic [1:0] v, input logic [1:0] g);
        @(negedge clk);
        gate_n_i = g; wheel_turn_i = v[0]; wheel_cw_i = v[1]; cap_clk_i = 1'b1;
        repeat (3) @(posedge clk);
    endtask

    task automatic cap_low();
        @(negedge clk);
        cap_clk_i = 1'b0; gate_n_i = 2'b00;
        repeat (3) @(posedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [8:0] r;
        repeat (3) @(posedge clk);
        // R1: during reset
        stat_read(r); check("R1 in reset", r, 9'h100);
        @(negedge clk) rst_n = 1'b1;
        stat_read(r); check("R1 after reset", r, 9'h100);

        // R4/R5/R2/R10: sweep values x gate settings
        for (int g = 0; g < 4; g++) begin
            for (int v = 0; v < 4; v++) begin
                clear_read("R6 oe low on clear");
                stat_read(r); check("R6 cleared", r, 9'h100);
                capture(v[1:0], g[1:0]);
                stat_read(r);
                if (g == 0) check("R4/R2 capture", r, {1'b1, 6'b0, v[1:0]});
                else        check("R5 gated", r, 9'h100);
                check("R10 upper zero", {3'b0, r[7:2]}, 9'h000);
                cap_low();
            end
        end

        // R9: level held high, inputs change, no reload
        clear_read("R6 oe low on clear");
        capture(2'b01, 2'b00);
        @(negedge clk) wheel_turn_i = 1'b0; wheel_cw_i = 1'b1;
        repeat (4) @(posedge clk);
        stat_read(r); check("R9 no reload on level", r, 9'h101);
        cap_low();

        // R3: address sweep and strobe high, flags = 11
        capture(2'b11, 2'b00);
        cap_low();
        for (int a = 16'h1000; a < 16'h1100; a++) begin
            if (a != 16'h1040 && a != 16'h1048) begin
                @(negedge clk);
                addr_i = a[15:0]; rd_n_i = 1'b0;
                #1 check("R3 other address", {rd_oe_o, rd_data_o}, 9'h000);
                #1 rd_n_i = 1'b1;
            end
        end
        @(negedge clk);
        addr_i = 16'h1040; rd_n_i = 1'b1;
        #1 check("R3 strobe high", {rd_oe_o, rd_data_o}, 9'h000);

        // R7: long status read across edges keeps flags
        @(negedge clk);
        rd_n_i = 1'b0;
        repeat (5) @(posedge clk);
        @(negedge clk);
        #1 check("R7 read no clear", {rd_oe_o, rd_data_o}, 9'h103);
        rd_n_i = 1'b1;
        stat_read(r); check("R7 after read", r, 9'h103);

        // R8: clear on same edge as capture fire
        clear_read("R6 oe low on clear");
        @(negedge clk);
        wheel_turn_i = 1'b1; wheel_cw_i = 1'b1; cap_clk_i = 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        addr_i = 16'h1048; rd_n_i = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rd_n_i = 1'b1;
        stat_read(r); check("R8 clear wins", r, 9'h100);
        repeat (3) @(posedge clk);
        stat_read(r); check("R8 no late load", r, 9'h100);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule